// File: doc/BRIEF.md
# Multi-Bit Word Clock-Domain Crossing

This block moves a whole data word from a source clock domain into an unrelated destination clock domain. The bits are not synchronized one by one. The word is captured into a holding register in the source domain. A single request bit then crosses to the destination, and that bit alone decides when the destination samples the word. Because the holding register does not change during a crossing, the destination always sees a settled word.

A write is requested by asserting the write strobe for one source cycle with the word on the data input. When the block is idle, it accepts the write, stores the word and flips a request toggle. The toggle passes through a chain of destination-clock flip-flops whose length is a parameter. An edge detector after the chain produces one pulse for each write. On that pulse the held word is copied into the output register, and the output valid strobe is raised for one destination cycle. The destination's view of the toggle is sent back through a second chain into the source domain as an acknowledge. The source-side busy flag stays high from acceptance until that acknowledge arrives. Any write strobe seen while busy is high is dropped.

Top module: `wordCdcSync`

## Requirements
- R1: While either reset is asserted and right after reset, dataValid is 0, dataOut is 0 and busy is 0.
- R2: A write strobe sampled at a source clock edge while busy is low is accepted, and busy is high after that edge.
- R3: Every accepted word appears on dataOut exactly once, marked by dataValid, unchanged in every bit.
- R4: dataValid is high for exactly one destination clock cycle per accepted word and never for two cycles in a row.
- R5: When dataValid is low, dataOut keeps the value it had in the previous destination cycle.
- R6: A write strobe sampled while busy is high is ignored: the held word does not change and no extra word is delivered.
- R7: Accepted words are delivered in the order they were accepted, with source and destination clocks of unrelated periods.
- R8: After an accepted write, busy returns low within a bounded number of source cycles once the destination has taken the word, so a new write can follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| srcClk | input | 1 | Source domain clock |
| srcRstN | input | 1 | Source domain reset, active low |
| dataIn | input | WIDTH | Word to transfer, sampled with writeStrobe |
| writeStrobe | input | 1 | Write request, one source cycle per word |
| busy | output | 1 | High while a crossing is in flight; writes are ignored |
| dstClk | input | 1 | Destination domain clock |
| dstRstN | input | 1 | Destination domain reset, active low |
| dataOut | output | WIDTH | Last word delivered, held between deliveries |
| dataValid | output | 1 | One-cycle strobe marking a newly delivered word |

## Verification
The source and destination clocks run at unrelated periods. The block is tested with three write patterns. Isolated writes that wait for busy to fall test the basic handshake and the busy timing. A write strobe held high without a break makes most requests arrive while busy is high, so it tests whether dropped writes stay dropped or leak through and corrupt the held word. A pseudo-random strobe pattern mixes both cases at different phases of the two clocks, which tests ordering and exactly-once delivery.

// File: rtl/wordCdcPkg.sv
package wordCdcPkg;
  // Strobes from the handshake control to the word path.
  typedef struct packed {
    logic captureSrc;  // source domain: load the holding register
    logic loadDst;     // destination domain: copy held word to output
  } xferStrobes_t;
endpackage

// File: rtl/wordCdcBitSync.sv
module wordCdcBitSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic bitIn,
  output logic bitOut
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= '0;
    end else begin
      chain[0] <= bitIn;
      for (int i = 1; i < STAGES; i++) begin
        chain[i] <= chain[i-1];
      end
    end
  end

  assign bitOut = chain[STAGES-1];
endmodule

// File: rtl/wordCdcCtrl.sv
module wordCdcCtrl
  import wordCdcPkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic         srcClk,
  input  logic         srcRstN,
  input  logic         writeStrobe,
  output logic         busy,
  input  logic         dstClk,
  input  logic         dstRstN,
  output xferStrobes_t strobes
);
  logic reqTgl;     // source: flips once per accepted write
  logic ackSeen;    // source: acknowledge toggle after synchronization
  logic reqSeen;    // destination: request toggle after synchronization
  logic reqPrev;    // destination: last consumed toggle, also the ack
  logic accept;
  logic edgePulse;

  assign busy   = reqTgl ^ ackSeen;
  assign accept = writeStrobe & ~busy;

  always_ff @(posedge srcClk or negedge srcRstN) begin
    if (!srcRstN) reqTgl <= 1'b0;
    else if (accept) reqTgl <= ~reqTgl;
  end

  wordCdcBitSync #(.STAGES(STAGES)) reqSyncU (
    .clk(dstClk), .rstN(dstRstN), .bitIn(reqTgl), .bitOut(reqSeen)
  );

  always_ff @(posedge dstClk or negedge dstRstN) begin
    if (!dstRstN) reqPrev <= 1'b0;
    else reqPrev <= reqSeen;
  end

  assign edgePulse = reqSeen ^ reqPrev;

  wordCdcBitSync #(.STAGES(STAGES)) ackSyncU (
    .clk(srcClk), .rstN(srcRstN), .bitIn(reqPrev), .bitOut(ackSeen)
  );

  assign strobes.captureSrc = accept;
  assign strobes.loadDst    = edgePulse;
endmodule

// File: rtl/wordCdcPath.sv
module wordCdcPath
  import wordCdcPkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             srcClk,
  input  logic             srcRstN,
  input  logic [WIDTH-1:0] dataIn,
  input  logic             dstClk,
  input  logic             dstRstN,
  input  xferStrobes_t     strobes,
  output logic [WIDTH-1:0] holdWord,
  output logic [WIDTH-1:0] dataOut,
  output logic             dataValid
);
  always_ff @(posedge srcClk or negedge srcRstN) begin
    if (!srcRstN) holdWord <= '0;
    else if (strobes.captureSrc) holdWord <= dataIn;
  end

  always_ff @(posedge dstClk or negedge dstRstN) begin
    if (!dstRstN) begin
      dataOut   <= '0;
      dataValid <= 1'b0;
    end else begin
      dataValid <= strobes.loadDst;
      if (strobes.loadDst) dataOut <= holdWord;
    end
  end
endmodule

// File: rtl/wordCdcSync.sv
module wordCdcSync
  import wordCdcPkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             srcClk,
  input  logic             srcRstN,
  input  logic [WIDTH-1:0] dataIn,
  input  logic             writeStrobe,
  output logic             busy,
  input  logic             dstClk,
  input  logic             dstRstN,
  output logic [WIDTH-1:0] dataOut,
  output logic             dataValid
);
  xferStrobes_t     strobes;
  logic [WIDTH-1:0] holdWord;

  wordCdcCtrl #(.STAGES(STAGES)) ctrlU (
    .srcClk(srcClk), .srcRstN(srcRstN), .writeStrobe(writeStrobe),
    .busy(busy), .dstClk(dstClk), .dstRstN(dstRstN), .strobes(strobes)
  );

  wordCdcPath #(.WIDTH(WIDTH)) pathU (
    .srcClk(srcClk), .srcRstN(srcRstN), .dataIn(dataIn),
    .dstClk(dstClk), .dstRstN(dstRstN), .strobes(strobes),
    .holdWord(holdWord), .dataOut(dataOut), .dataValid(dataValid)
  );
endmodule

// File: rtl/wordCdcSyncChk.sv
module wordCdcSyncChk #(
  parameter int WIDTH = 16
) (
  input logic             srcClk,
  input logic             srcRstN,
  input logic             writeStrobe,
  input logic             busy,
  input logic [WIDTH-1:0] holdWord,
  input logic             dstClk,
  input logic             dstRstN,
  input logic [WIDTH-1:0] dataOut,
  input logic             dataValid
);
  // R1
  always @(posedge dstClk) begin
    if (!dstRstN) reset_quiet_chk: assert (!dataValid);
  end

  // R2
  busy_after_accept_chk: assert property (@(posedge srcClk) disable iff (!srcRstN)
    (writeStrobe && !busy) |=> busy);

  // R6
  ignored_write_chk: assert property (@(posedge srcClk) disable iff (!srcRstN)
    (busy || !writeStrobe) |=> $stable(holdWord));

  // R4
  single_pulse_chk: assert property (@(posedge dstClk) disable iff (!dstRstN)
    dataValid |=> !dataValid);

  // R5
  hold_output_chk: assert property (@(posedge dstClk) disable iff (!dstRstN)
    !dataValid |-> $stable(dataOut));
endmodule

bind wordCdcSync wordCdcSyncChk #(.WIDTH(WIDTH)) chkU (
  .srcClk(srcClk), .srcRstN(srcRstN), .writeStrobe(writeStrobe),
  .busy(busy), .holdWord(holdWord), .dstClk(dstClk), .dstRstN(dstRstN),
  .dataOut(dataOut), .dataValid(dataValid)
);

// File: tb/tb_wordCdcSync.sv
module tb_wordCdcSync;
  localparam int SRC_PERIOD = 10;
  localparam int DST_PERIOD = 17;
  localparam int WIDTH      = 16;
  localparam int BUSY_LIMIT = 30;

  logic             srcClk = 0, dstClk = 0;
  logic             srcRstN = 0, dstRstN = 0;
  logic [WIDTH-1:0] dataIn = '0;
  logic             writeStrobe = 0;
  logic             busy, dataValid;
  logic [WIDTH-1:0] dataOut;

  int errors = 0, checks = 0;
  logic [WIDTH-1:0] expQ[$];
  int acceptedCnt = 0, deliveredCnt = 0;
  logic [WIDTH-1:0] seqVal = 16'h0100;
  logic [WIDTH-1:0] lastOut = '0;
  logic prevValid = 0;
  logic pendBusyChk = 0;
  int busyRun = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic finished = 0;

  always #(SRC_PERIOD/2) srcClk = ~srcClk;
  always #(DST_PERIOD/2) dstClk = ~dstClk;

  wordCdcSync #(.WIDTH(WIDTH), .STAGES(2)) dut (
    .srcClk(srcClk), .srcRstN(srcRstN), .dataIn(dataIn),
    .writeStrobe(writeStrobe), .busy(busy), .dstClk(dstClk),
    .dstRstN(dstRstN), .dataOut(dataOut), .dataValid(dataValid)
  );

  task automatic check(input logic ok, input string req,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // One source cycle: drive at the falling edge, acceptance predicted
  // from the busy level, which only moves at rising edges.
  task automatic tick(input logic en);
    @(negedge srcClk);
    if (pendBusyChk) check(busy == 1'b1, "R2", busy, 1);
    if (busy) busyRun++;
    else begin
      if (busyRun > 0) check(busyRun <= BUSY_LIMIT, "R8", busyRun, BUSY_LIMIT);
      busyRun = 0;
    end
    writeStrobe = en;
    pendBusyChk = 0;
    if (en && !busy) begin
      dataIn = seqVal;
      expQ.push_back(seqVal);
      acceptedCnt++;
      seqVal = seqVal + 16'h0137;
      pendBusyChk = 1;
    end else begin
      dataIn = 16'hF000 | 16'(busyRun);  // R6: must never be delivered
    end
  endtask

  // Destination reference: compare on every destination cycle.
  always @(negedge dstClk) begin
    if (dstRstN && !finished) begin
      if (dataValid) begin
        check(!prevValid, "R4", 1, 0);
        if (expQ.size() == 0) check(1'b0, "R6", dataOut, 0);
        else begin
          check(dataOut == expQ[0], "R3 R7", dataOut, expQ[0]);
          void'(expQ.pop_front());
        end
        deliveredCnt++;
        lastOut = dataOut;
      end else begin
        check(dataOut == lastOut, "R5", dataOut, lastOut);
      end
      prevValid = dataValid;
    end
  end

  initial begin
    #(SRC_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", deliveredCnt, acceptedCnt);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge dstClk);
    // R1: outputs quiet during reset
    check(dataValid == 0, "R1", dataValid, 0);
    check(dataOut == 0, "R1", dataOut, 0);
    check(busy == 0, "R1", busy, 0);
    @(negedge srcClk); srcRstN = 1;
    @(negedge dstClk); dstRstN = 1;
    repeat (2) @(negedge srcClk);
    check(busy == 0, "R1", busy, 0);
    check(dataValid == 0 && dataOut == 0, "R1", dataOut, 0);

    // Pattern 1: isolated writes, waiting for idle
    for (int k = 0; k < 20; k++) begin
      tick(1);
      tick(0);
      while (busy) tick(0);
      repeat (k % 3) tick(0);
    end

    // Pattern 2: strobe held high continuously
    for (int k = 0; k < 400; k++) tick(1);
    tick(0);

    // Pattern 3: pseudo-random strobes
    for (int k = 0; k < 2000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      tick(lfsr[0] & lfsr[3]);
    end

    // Drain
    for (int k = 0; k < 60; k++) tick(0);
    repeat (4) @(negedge dstClk);
    check(expQ.size() == 0, "R3", expQ.size(), 0);
    check(deliveredCnt == acceptedCnt, "R3 R6", deliveredCnt, acceptedCnt);
    check(acceptedCnt > 40, "R2", acceptedCnt, 41);
    check(busy == 0, "R8", busy, 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule